// File: doc/BRIEF.md
# UART Software and Hardware Flow Controller

This block sits between the receive shifter, the receive FIFO and the transmit shifter of a UART. It handles flow control and does no serial shifting. Each received byte arrives on a one-cycle strobe. The block compares the byte against four programmable flow characters: two "resume" characters and two "pause" characters, each 8 bits wide. Flow characters that match are removed from the data stream. Every other byte is forwarded to the receive FIFO. A matched pause sets a sticky paused state, and a matched resume clears it. While paused, the transmitter is refused permission to start a new character. A matched pause can also raise a latched interrupt request.

A 2-bit receive mode selects what counts as a match:
- single characters from set 1;
- single characters from set 2;
- two-byte words, made of the set-1 character followed by the set-2 character.

A 2-bit transmit mode with the same encoding lets the block insert its own pause and resume characters toward the far end. It sends a pause when the local receive FIFO fill reaches the trigger level, and a resume when the fill drops back below it.

Two hardware options sit alongside the software scheme. Auto-CTS blocks new transmit starts while the synchronized clear-to-send input is inactive. Auto-RTS drops the request-to-send output while the receive FIFO is at or above the trigger level. A character that the shifter has already started always completes, because the block only gates the start of new characters.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `xoff_status` = 0, `xoff_irq` = 0, `ins_req` = 0, `pass_valid` = 0 and `rts_active` = 1.
- R2: With `rx_mode` = 1, a received byte equal to `xoff1` sets `xoff_status` on the clock edge that samples it, and a byte equal to `xon1` clears it. Neither byte is forwarded. Any other byte appears on `pass_byte` with `pass_valid` = 1 after that same edge.
- R3: With `rx_mode` = 2, only `xon2` and `xoff2` act as flow characters. A byte equal to `xon1` or `xoff1` is forwarded as data and leaves `xoff_status` unchanged.
- R4: With `rx_mode` = 0, every byte is forwarded and `xoff_status` is unchanged.
- R5: With `rx_mode` = 3, the sequence `xoff1` then `xoff2` sets `xoff_status`, and the sequence `xon1` then `xon2` clears it. No byte of a completed pair is forwarded.
- R6: With `rx_mode` = 3, when a held first byte is followed by a byte that does not complete the pair, the held byte is forwarded after that edge. The new byte follows one cycle later, unless it is itself `xon1` or `xoff1`, in which case it becomes the new held byte. Received strobes are at least two cycles apart.
- R7: A pause match sets `xoff_irq` only when `xoff_irq_en` = 1. Once set, `xoff_irq` stays high until a cycle with `irq_clr` = 1 clears it.
- R8: `tx_start_ok` is 1 only when `tx_fifo_nonempty` = 1, `tx_busy` = 0, `xoff_status` = 0 and `ins_req` = 0, and the auto-CTS condition of R9 allows it.
- R9: With `auto_cts_en` = 1, `tx_start_ok` is 0 once `cts_active` has been 0 for the `SYNC_STAGES` (default 2) synchronizer edges. With `auto_cts_en` = 0, `cts_active` has no effect.
- R10: While `tx_busy` = 1, `tx_start_ok` is 0. A character in flight is never cut short, because only new starts are gated.
- R11: With `tx_mode` not equal to 0, `rx_fifo_level` reaching `rx_trig_level` raises `ins_req` on the next edge with a pause character, and a later drop below the trigger level raises a resume character:
  - mode 1 inserts `xoff1` or `xon1`;
  - mode 2 inserts `xoff2` or `xon2`;
  - mode 3 inserts two characters: `xoff1` then `xoff2`, or `xon1` then `xon2`.

  Each character is held until `ins_ack`. After a pause has been sent, no second pause is sent while the fill stays high.
- R12: With `auto_rts_en` = 1, `rts_active` is 0 one edge after `rx_fifo_level` is at or above `rx_trig_level`, and 1 one edge after the level falls below it. With `auto_rts_en` = 0, `rts_active` is 1.
- R13: While `ins_req` = 1, `tx_start_ok` is 0, so an inserted flow character takes priority over FIFO data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_mode | input | 2 | Receive flow mode: 0 none, 1 set 1, 2 set 2, 3 two-byte words |
| tx_mode | input | 2 | Transmit flow mode, same encoding |
| xon1 | input | 8 | Resume character, set 1 |
| xon2 | input | 8 | Resume character, set 2 |
| xoff1 | input | 8 | Pause character, set 1 |
| xoff2 | input | 8 | Pause character, set 2 |
| xoff_irq_en | input | 1 | Enables the pause interrupt request |
| auto_cts_en | input | 1 | Enables CTS gating of transmit starts |
| auto_rts_en | input | 1 | Enables RTS driven from the receive FIFO fill |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| pass_valid | output | 1 | Forwarded byte valid, toward the receive FIFO |
| pass_byte | output | 8 | Forwarded byte |
| xoff_status | output | 1 | Paused by the far end |
| xoff_irq | output | 1 | Latched pause interrupt request |
| irq_clr | input | 1 | Clears `xoff_irq` |
| rx_fifo_level | input | 5 | Current receive FIFO fill |
| rx_trig_level | input | 5 | Receive FIFO trigger level |
| rts_active | output | 1 | Request-to-send, 1 = asserted |
| cts_active | input | 1 | Clear-to-send, 1 = asserted, asynchronous |
| tx_fifo_nonempty | input | 1 | Transmit FIFO holds data |
| tx_busy | input | 1 | Transmit shifter is sending a character |
| tx_start_ok | output | 1 | Permission to start the next FIFO character |
| ins_req | output | 1 | Request to send a flow character |
| ins_char | output | 8 | Flow character to send |
| ins_ack | input | 1 | Shifter accepted `ins_char` |

## Verification
A wrong paused state shows within one cycle: `tx_start_ok` stays low, or `xoff_status` disagrees with the last matched flow character. A wrong held-byte state in two-byte mode shows within two cycles as a missing, duplicated or reordered byte on `pass_byte`. A wrong insertion state shows on `ins_req` and `ins_char` on the edge after the fill crosses the trigger level, or as a repeated or skipped second character after `ins_ack`. An error in the CTS path shows only after the synchronizer depth.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

    typedef enum logic [1:0] {
        FLOW_NONE = 2'd0,
        FLOW_SET1 = 2'd1,
        FLOW_SET2 = 2'd2,
        FLOW_PAIR = 2'd3
    } flow_mode_e;

    typedef enum logic [1:0] {
        INS_IDLE   = 2'd0,
        INS_FIRST  = 2'd1,
        INS_SECOND = 2'd2
    } ins_state_e;

endpackage

// File: rtl/uart_flow_sync.sv
module uart_flow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_flow_rx_match.sv
module uart_flow_rx_match
    import uart_flow_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rx_mode,
    input  logic [DATA_W-1:0] xon1,
    input  logic [DATA_W-1:0] xon2,
    input  logic [DATA_W-1:0] xoff1,
    input  logic [DATA_W-1:0] xoff2,
    input  logic              xoff_irq_en,
    input  logic              irq_clr,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              pass_valid,
    output logic [DATA_W-1:0] pass_byte,
    output logic              xoff_status,
    output logic              xoff_irq
);
    typedef struct packed {
        logic              paused;
        logic              irq;
        logic              held_on;
        logic              held_off;
        logic [DATA_W-1:0] held_byte;
        logic              pend_v;
        logic [DATA_W-1:0] pend_byte;
        logic              out_v;
        logic [DATA_W-1:0] out_byte;
    } rx_state_t;

    rx_state_t st_d, st_q;
    flow_mode_e mode;

    assign mode = flow_mode_e'(rx_mode);

    always_comb begin : p_next
        logic held;
        logic done;
        logic fwd;
        st_d       = st_q;
        st_d.out_v = 1'b0;
        held       = st_q.held_on | st_q.held_off;
        done       = 1'b0;
        fwd        = 1'b0;

        if (st_q.pend_v) begin
            st_d.out_v    = 1'b1;
            st_d.out_byte = st_q.pend_byte;
            st_d.pend_v   = 1'b0;
        end
        if (irq_clr) st_d.irq = 1'b0;

        if (rx_valid) begin
            if (mode == FLOW_PAIR && held) begin
                if (st_q.held_off && rx_byte == xoff2) begin
                    st_d.paused = 1'b1;
                    if (xoff_irq_en) st_d.irq = 1'b1;
                    done = 1'b1;
                end else if (st_q.held_on && rx_byte == xon2) begin
                    st_d.paused = 1'b0;
                    done = 1'b1;
                end
            end
            st_d.held_on  = 1'b0;
            st_d.held_off = 1'b0;
            if (!done) begin
                if (held) begin
                    st_d.out_v    = 1'b1;
                    st_d.out_byte = st_q.held_byte;
                end
                case (mode)
                    FLOW_SET1: begin
                        if (rx_byte == xoff1) begin
                            st_d.paused = 1'b1;
                            if (xoff_irq_en) st_d.irq = 1'b1;
                        end else if (rx_byte == xon1) begin
                            st_d.paused = 1'b0;
                        end else begin
                            fwd = 1'b1;
                        end
                    end
                    FLOW_SET2: begin
                        if (rx_byte == xoff2) begin
                            st_d.paused = 1'b1;
                            if (xoff_irq_en) st_d.irq = 1'b1;
                        end else if (rx_byte == xon2) begin
                            st_d.paused = 1'b0;
                        end else begin
                            fwd = 1'b1;
                        end
                    end
                    FLOW_PAIR: begin
                        if (rx_byte == xoff1 || rx_byte == xon1) begin
                            st_d.held_off  = (rx_byte == xoff1);
                            st_d.held_on   = (rx_byte == xon1);
                            st_d.held_byte = rx_byte;
                        end else begin
                            fwd = 1'b1;
                        end
                    end
                    default: fwd = 1'b1;
                endcase
                if (fwd) begin
                    if (held) begin
                        st_d.pend_v    = 1'b1;
                        st_d.pend_byte = rx_byte;
                    end else begin
                        st_d.out_v    = 1'b1;
                        st_d.out_byte = rx_byte;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pass_valid  = st_q.out_v;
    assign pass_byte   = st_q.out_byte;
    assign xoff_status = st_q.paused;
    assign xoff_irq    = st_q.irq;

    assert_xoff_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_mode == 2'd1 && rx_byte == xoff1) |=> xoff_status);

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xoff_irq && !irq_clr) |=> xoff_irq);

    assert_mode0_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_mode == 2'd0 && !(st_q.held_on || st_q.held_off))
        |=> (pass_valid && pass_byte == $past(rx_byte)));

    assert_pair_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_mode == 2'd3 && st_q.held_off && rx_byte == xoff2)
        |=> (xoff_status && !pass_valid));
endmodule

// File: rtl/uart_flow_tx_ins.sv
module uart_flow_tx_ins
    import uart_flow_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tx_mode,
    input  logic [DATA_W-1:0] xon1,
    input  logic [DATA_W-1:0] xon2,
    input  logic [DATA_W-1:0] xoff1,
    input  logic [DATA_W-1:0] xoff2,
    input  logic              fill_hi,
    input  logic              ins_ack,
    output logic              ins_req,
    output logic [DATA_W-1:0] ins_char
);
    typedef struct packed {
        ins_state_e state;
        logic       is_off;
        logic       set2;
        logic       pair;
        logic       stopped;
    } ins_reg_t;

    ins_reg_t r_d, r_q;
    flow_mode_e mode;

    assign mode = flow_mode_e'(tx_mode);

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            INS_IDLE: begin
                if (mode != FLOW_NONE && fill_hi != r_q.stopped) begin
                    r_d.state   = INS_FIRST;
                    r_d.is_off  = fill_hi;
                    r_d.stopped = fill_hi;
                    r_d.set2    = (mode == FLOW_SET2);
                    r_d.pair    = (mode == FLOW_PAIR);
                end
            end
            INS_FIRST: begin
                if (ins_ack) r_d.state = r_q.pair ? INS_SECOND : INS_IDLE;
            end
            INS_SECOND: begin
                if (ins_ack) r_d.state = INS_IDLE;
            end
            default: r_d.state = INS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: INS_IDLE, default: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        if (r_q.state == INS_SECOND)
            ins_char = r_q.is_off ? xoff2 : xon2;
        else if (r_q.set2)
            ins_char = r_q.is_off ? xoff2 : xon2;
        else
            ins_char = r_q.is_off ? xoff1 : xon1;
    end

    assign ins_req = (r_q.state != INS_IDLE);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_ack) |=> (ins_req && $stable(ins_char)));
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
    parameter int DATA_W      = 8,
    parameter int LVL_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rx_mode,
    input  logic [1:0]        tx_mode,
    input  logic [DATA_W-1:0] xon1,
    input  logic [DATA_W-1:0] xon2,
    input  logic [DATA_W-1:0] xoff1,
    input  logic [DATA_W-1:0] xoff2,
    input  logic              xoff_irq_en,
    input  logic              auto_cts_en,
    input  logic              auto_rts_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              pass_valid,
    output logic [DATA_W-1:0] pass_byte,
    output logic              xoff_status,
    output logic              xoff_irq,
    input  logic              irq_clr,
    input  logic [LVL_W-1:0]  rx_fifo_level,
    input  logic [LVL_W-1:0]  rx_trig_level,
    output logic              rts_active,
    input  logic              cts_active,
    input  logic              tx_fifo_nonempty,
    input  logic              tx_busy,
    output logic              tx_start_ok,
    output logic              ins_req,
    output logic [DATA_W-1:0] ins_char,
    input  logic              ins_ack
);
    logic fill_hi;
    logic cts_sync;
    logic cts_ok;
    logic rts_d, rts_q;

    assign fill_hi = (rx_fifo_level >= rx_trig_level);

    uart_flow_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_active),
        .sync_out (cts_sync)
    );

    uart_flow_rx_match #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_mode     (rx_mode),
        .xon1        (xon1),
        .xon2        (xon2),
        .xoff1       (xoff1),
        .xoff2       (xoff2),
        .xoff_irq_en (xoff_irq_en),
        .irq_clr     (irq_clr),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .pass_valid  (pass_valid),
        .pass_byte   (pass_byte),
        .xoff_status (xoff_status),
        .xoff_irq    (xoff_irq)
    );

    uart_flow_tx_ins #(.DATA_W(DATA_W)) u_ins (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_mode  (tx_mode),
        .xon1     (xon1),
        .xon2     (xon2),
        .xoff1    (xoff1),
        .xoff2    (xoff2),
        .fill_hi  (fill_hi),
        .ins_ack  (ins_ack),
        .ins_req  (ins_req),
        .ins_char (ins_char)
    );

    always_comb begin
        rts_d = !(auto_rts_en && fill_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rts_q <= 1'b1;
        else        rts_q <= rts_d;
    end

    assign rts_active  = rts_q;
    assign cts_ok      = !auto_cts_en || cts_sync;
    assign tx_start_ok = tx_fifo_nonempty && !tx_busy && !xoff_status
                         && cts_ok && !ins_req;

    assert_rts_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_fifo_level >= rx_trig_level) |=> !rts_active);

    assert_paused_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_valid && rx_mode == 2'd1 && rx_byte == xoff1) |-> !tx_start_ok);
endmodule

// File: tb/sim_uart_flow_ctrl.sv
module sim_uart_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_mode = 2'd0, tx_mode = 2'd0;
    logic [7:0] xon1 = 8'h11, xon2 = 8'h91, xoff1 = 8'h13, xoff2 = 8'h93;
    logic       xoff_irq_en = 1'b0, auto_cts_en = 1'b0, auto_rts_en = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       pass_valid, xoff_status, xoff_irq, rts_active, tx_start_ok, ins_req;
    logic [7:0] pass_byte, ins_char;
    logic       irq_clr = 1'b0;
    logic [4:0] rx_fifo_level = 5'd0, rx_trig_level = 5'd8;
    logic       cts_active = 1'b1, tx_fifo_nonempty = 1'b0, tx_busy = 1'b0, ins_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_flow_ctrl u0 (.*);

    // {rx_mode[1:0], byte[7:0], expect_pass, expect_xoff}
    localparam logic [11:0] VEC [10] = '{
        {2'd1, 8'h41, 1'b1, 1'b0},
        {2'd1, 8'h13, 1'b0, 1'b1},
        {2'd1, 8'h41, 1'b1, 1'b1},
        {2'd1, 8'h11, 1'b0, 1'b0},
        {2'd1, 8'h93, 1'b1, 1'b0},
        {2'd2, 8'h13, 1'b1, 1'b0},
        {2'd2, 8'h93, 1'b0, 1'b1},
        {2'd2, 8'h11, 1'b1, 1'b1},
        {2'd2, 8'h91, 1'b0, 1'b0},
        {2'd0, 8'h13, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic ack();
        ins_ack = 1'b1;
        tick();
        ins_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 xoff", xoff_status, 0);
        chk("R1 irq", xoff_irq, 0);
        chk("R1 ins_req", ins_req, 0);
        chk("R1 pass", pass_valid, 0);
        chk("R1 rts", rts_active, 1);
        rst_n = 1'b1;
        tick();

        // Table: R2 (mode 1), R3 (mode 2), R4 (mode 0)
        foreach (VEC[i]) begin
            string rq;
            rq = (VEC[i][11:10] == 2'd1) ? "R2" : (VEC[i][11:10] == 2'd2) ? "R3" : "R4";
            rx_mode = VEC[i][11:10];
            send(VEC[i][9:2]);
            chk({rq, " pass_valid"}, pass_valid, VEC[i][1]);
            if (VEC[i][1]) chk({rq, " pass_byte"}, pass_byte, VEC[i][9:2]);
            chk({rq, " xoff"}, xoff_status, VEC[i][0]);
            tick();
        end

        // R5 two-byte words
        rx_mode = 2'd3;
        send(8'h13);
        chk("R5 held not passed", pass_valid, 0);
        tick();
        send(8'h93);
        chk("R5 pair sets xoff", xoff_status, 1);
        chk("R5 pair dropped", pass_valid, 0);
        tick();
        chk("R5 nothing late", pass_valid, 0);
        send(8'h11);
        tick();
        send(8'h91);
        chk("R5 pair clears xoff", xoff_status, 0);
        chk("R5 pair dropped on", pass_valid, 0);
        tick();

        // R6 partial match resets
        send(8'h13);
        tick();
        send(8'h55);
        chk("R6 held released", pass_valid, 1);
        chk("R6 held byte", pass_byte, 8'h13);
        chk("R6 xoff unchanged", xoff_status, 0);
        tick();
        chk("R6 new byte next", pass_valid, 1);
        chk("R6 new byte value", pass_byte, 8'h55);
        send(8'h13);
        tick();
        send(8'h93);
        chk("R6 setup xoff", xoff_status, 1);
        tick();
        send(8'h13);
        tick();
        send(8'h11);
        chk("R6 released first", pass_byte, 8'h13);
        tick();
        chk("R6 new first held", pass_valid, 0);
        send(8'h91);
        chk("R6 rehold completes", xoff_status, 0);
        chk("R6 rehold dropped", pass_valid, 0);
        tick();

        // R7 interrupt
        rx_mode = 2'd1;
        send(8'h13);
        chk("R7 no irq when disabled", xoff_irq, 0);
        tick();
        send(8'h11);
        tick();
        xoff_irq_en = 1'b1;
        send(8'h13);
        chk("R7 irq set", xoff_irq, 1);
        tick();
        tick();
        chk("R7 irq held", xoff_irq, 1);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        chk("R7 irq cleared", xoff_irq, 0);

        // R8 paused gating (xoff_status is 1 here)
        tx_fifo_nonempty = 1'b1;
        #1;
        chk("R8 paused blocks start", tx_start_ok, 0);
        send(8'h11);
        chk("R8 resumed allows start", tx_start_ok, 1);
        tick();
        // R10 busy
        tx_busy = 1'b1;
        #1;
        chk("R10 busy blocks start", tx_start_ok, 0);
        tx_busy = 1'b0;
        #1;
        chk("R10 idle allows start", tx_start_ok, 1);
        // R9 auto CTS
        cts_active = 1'b0;
        tick();
        tick();
        tick();
        chk("R9 cts ignored when disabled", tx_start_ok, 1);
        auto_cts_en = 1'b1;
        #1;
        chk("R9 cts inactive blocks", tx_start_ok, 0);
        cts_active = 1'b1;
        tick();
        tick();
        tick();
        chk("R9 cts active allows", tx_start_ok, 1);
        auto_cts_en = 1'b0;

        // R11 / R13 insertion, two-byte mode
        tx_mode = 2'd3;
        rx_fifo_level = 5'd8;
        tick();
        chk("R11 pause req", ins_req, 1);
        chk("R11 pause first", ins_char, 8'h13);
        chk("R13 insert blocks start", tx_start_ok, 0);
        tick();
        tick();
        chk("R11 held until ack", ins_char, 8'h13);
        ack();
        chk("R11 second still req", ins_req, 1);
        chk("R11 pause second", ins_char, 8'h93);
        ack();
        chk("R11 done", ins_req, 0);
        tick();
        chk("R11 no repeat pause", ins_req, 0);
        rx_fifo_level = 5'd3;
        tick();
        chk("R11 resume first", ins_char, 8'h11);
        ack();
        chk("R11 resume second", ins_char, 8'h91);
        ack();
        chk("R11 resume done", ins_req, 0);
        // single set 2
        tx_mode = 2'd2;
        rx_fifo_level = 5'd9;
        tick();
        chk("R11 set2 pause", ins_char, 8'h93);
        ack();
        chk("R11 set2 single", ins_req, 0);
        rx_fifo_level = 5'd0;
        tick();
        chk("R11 set2 resume", ins_char, 8'h91);
        ack();
        tx_mode = 2'd0;

        // R12 auto RTS
        rx_fifo_level = 5'd8;
        tick();
        chk("R12 rts kept when disabled", rts_active, 1);
        auto_rts_en = 1'b1;
        tick();
        chk("R12 rts drops at trigger", rts_active, 0);
        rx_fifo_level = 5'd7;
        tick();
        chk("R12 rts returns below", rts_active, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule